// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a host on a 16-bit register bus reach the internal registers of up to five embedded PHYs without a dedicated port for each. The host chooses read or write in a control register. It then writes to a bus address whose upper bit marks a PHY access. The low address bits of that trigger write carry the register number and page, and a one-hot group of address bits names the target PHY. On a write, the bus data of that same write is the value sent to the PHY.

The PHY side is a parallel request/acknowledge port. The block issues a single-cycle request with the decoded fields held steady, and it stays busy until one acknowledge comes back. On a read acknowledge, the returned word is captured into a data register that the host then reads. A trigger address that does not select exactly one valid PHY sets an error status bit and issues no request.

Top module: `phy_window_bridge`

## Requirements
- R1: After reset, no request is pending, the busy and error status bits are 0, the operation bit is 0 (write) and the data register reads 0.
- R2: The control register at 0x8028 stores only bit 0 (1 = read, 0 = write). Reading it returns bit 0 = operation, bit 1 = busy, bit 2 = error, and 0 in all other bits.
- R3: A bus write with address bit 15 set, to any address other than 0x8028 or 0x8029, that selects one valid PHY produces exactly one request pulse, one cycle long, in the cycle after the write. The request carries register number = address bits 4:0, page = address bits 7:5, and a one-hot PHY select equal to address bits 13:9 (PHY n is bit 9+n).
- R4: When the operation is write, the request has write enable 1, and its write data equals the bus data of the trigger write.
- R5: When the operation is read, the request has write enable 0 and write data 0, so the trigger write data is ignored.
- R6: A read acknowledge loads the returned PHY word into the data register at 0x8029. The register keeps that value through write completions and stray acknowledges until the next read completes.
- R7: Busy is set by an accepted trigger and held until the acknowledge. The request fields stay stable while busy.
- R8: Trigger writes that arrive while busy, valid or not, issue no request and leave the error bit unchanged.
- R9: A trigger with no PHY bit set, with more than one PHY bit set, or with address bit 14 set issues no request and sets the error bit. The next accepted valid trigger clears the error bit.
- R10: Bus writes with address bit 15 clear issue no request and change no register.
- R11: An acknowledge that arrives while not busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Host write strobe |
| bus_addr_i | input | 16 | Host address, for writes and for the combinational read |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (control, data, or 0) |
| phy_req_o | output | 1 | One-cycle PHY request strobe |
| phy_sel_o | output | 5 | One-hot PHY select |
| phy_page_o | output | 3 | PHY register page |
| phy_reg_o | output | 5 | PHY register number |
| phy_wr_en_o | output | 1 | 1 = write request, 0 = read request |
| phy_wr_data_o | output | 16 | Data for a write request |
| phy_ack_i | input | 1 | PHY acknowledge, one per request |
| phy_rdata_i | input | 16 | PHY read data, valid with the acknowledge |

## Verification
The assertions check on every cycle that the request strobe lasts a single cycle and carries exactly one PHY select bit, that busy holds until an acknowledge and keeps the request fields frozen, that no request leaves while busy or in the cycle an error is raised, that read requests carry zero write data, and that the data register moves only on a read acknowledge. Only the bench scenarios can show that the address fields map to the right request fields and that write data reaches the PHY. The same holds for rejection of each malformed select pattern and for error clearing on the next good trigger. It also holds for the data register surviving a write completion, a stray acknowledge and triggers dropped while busy.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } phy_op_e;

  // status bit positions in the control register readback
  localparam int unsigned ST_OP   = 0;
  localparam int unsigned ST_BUSY = 1;
  localparam int unsigned ST_ERR  = 2;
  localparam int unsigned ST_W    = 3;
endpackage

// File: rtl/pb_addr_decode.sv
module pb_addr_decode #(
  parameter int unsigned NUM_PHY = 5,
  parameter int unsigned SEL_W   = 6,
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned REG_W   = 5
) (
  input  logic [SEL_W-1:0]   sel_field_i,
  input  logic [PAGE_W-1:0]  page_field_i,
  input  logic [REG_W-1:0]   reg_field_i,
  output logic [NUM_PHY-1:0] phy_sel_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [REG_W-1:0]   reg_o,
  output logic               sel_ok_o
);
  localparam int unsigned CNT_W = $clog2(NUM_PHY + 1);

  logic             high_set;
  logic [CNT_W-1:0] ones;

  generate
    if (SEL_W > NUM_PHY) begin : g_high
      assign high_set = |sel_field_i[SEL_W-1:NUM_PHY];
    end else begin : g_nohigh
      assign high_set = 1'b0;
    end
  endgenerate

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_PHY; i++) ones = ones + CNT_W'(sel_field_i[i]);
  end

  assign phy_sel_o = sel_field_i[NUM_PHY-1:0];
  assign page_o    = page_field_i;
  assign reg_o     = reg_field_i;
  assign sel_ok_o  = !high_set && (ones == CNT_W'(1));
endmodule

// File: rtl/pb_host_regs.sv
module pb_host_regs
  import phy_bridge_pkg::*;
#(
  parameter int unsigned       DW        = 16,
  parameter int unsigned       AW        = 16,
  parameter logic [AW-1:0]     CTRL_ADDR = 16'h8028,
  parameter logic [AW-1:0]     DATA_ADDR = 16'h8029
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          op_bit_i,
  input  logic          busy_i,
  input  logic          err_i,
  input  logic          rd_done_i,
  input  logic [DW-1:0] rd_value_i,
  output phy_op_e       op_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] rdata_o,
  output logic          is_reg_o
);
  logic hit_ctrl, hit_data;

  assign hit_ctrl = (bus_addr_i == CTRL_ADDR);
  assign hit_data = (bus_addr_i == DATA_ADDR);
  assign is_reg_o = hit_ctrl || hit_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_o <= OP_WRITE;
    else if (bus_wr_i && hit_ctrl) op_o <= phy_op_e'(op_bit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else if (rd_done_i) data_o <= rd_value_i;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[ST_OP]   = (op_o == OP_READ);
      rdata_o[ST_BUSY] = busy_i;
      rdata_o[ST_ERR]  = err_i;
    end else if (hit_data) begin
      rdata_o = data_o;
    end
  end
endmodule

// File: rtl/pb_req_ctrl.sv
module pb_req_ctrl
  import phy_bridge_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned NUM_PHY = 5,
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned REG_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic               sel_ok_i,
  input  logic [NUM_PHY-1:0] sel_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [REG_W-1:0]   reg_i,
  input  phy_op_e            op_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic [NUM_PHY-1:0] sel_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [REG_W-1:0]   reg_o,
  output logic               wr_en_o,
  output logic [DW-1:0]      wr_data_o,
  output logic               busy_o,
  output logic               err_o,
  output logic               rd_done_o
);
  logic accept;

  assign accept    = trig_i && !busy_o;
  assign rd_done_o = busy_o && ack_i && !wr_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o     <= 1'b0;
      busy_o    <= 1'b0;
      err_o     <= 1'b0;
      sel_o     <= '0;
      page_o    <= '0;
      reg_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      req_o <= 1'b0;
      if (busy_o && ack_i) busy_o <= 1'b0;
      if (accept) begin
        if (sel_ok_i) begin
          req_o     <= 1'b1;
          busy_o    <= 1'b1;
          err_o     <= 1'b0;
          sel_o     <= sel_i;
          page_o    <= page_i;
          reg_o     <= reg_i;
          wr_en_o   <= (op_i == OP_WRITE);
          wr_data_o <= (op_i == OP_WRITE) ? wdata_i : '0;
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phy_window_bridge.sv
module phy_window_bridge
  import phy_bridge_pkg::*;
#(
  parameter int unsigned   DW        = 16,
  parameter int unsigned   AW        = 16,
  parameter int unsigned   NUM_PHY   = 5,
  parameter int unsigned   SEL_LSB   = 9,
  parameter int unsigned   PAGE_W    = 3,
  parameter int unsigned   REG_W     = 5,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [AW-1:0] DATA_ADDR = 16'h8029
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               phy_req_o,
  output logic [NUM_PHY-1:0] phy_sel_o,
  output logic [PAGE_W-1:0]  phy_page_o,
  output logic [REG_W-1:0]   phy_reg_o,
  output logic               phy_wr_en_o,
  output logic [DW-1:0]      phy_wr_data_o,
  input  logic               phy_ack_i,
  input  logic [DW-1:0]      phy_rdata_i
);
  localparam int unsigned TRIG_BIT = AW - 1;
  localparam int unsigned SEL_W    = TRIG_BIT - SEL_LSB;
  localparam int unsigned PAGE_LSB = REG_W;

  phy_op_e               op_q;
  logic [DW-1:0]         data_q;
  logic                  busy_q, err_q, rd_done, is_reg, trig, sel_ok;
  logic [NUM_PHY-1:0]    dec_sel;
  logic [PAGE_W-1:0]     dec_page;
  logic [REG_W-1:0]      dec_reg;

  // register addresses live inside the trigger window and take precedence
  assign trig = bus_wr_i && bus_addr_i[TRIG_BIT] && !is_reg;

  pb_host_regs #(
    .DW(DW), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .op_bit_i   (bus_wdata_i[0]),
    .busy_i     (busy_q),
    .err_i      (err_q),
    .rd_done_i  (rd_done),
    .rd_value_i (phy_rdata_i),
    .op_o       (op_q),
    .data_o     (data_q),
    .rdata_o    (bus_rdata_o),
    .is_reg_o   (is_reg)
  );

  pb_addr_decode #(
    .NUM_PHY(NUM_PHY), .SEL_W(SEL_W), .PAGE_W(PAGE_W), .REG_W(REG_W)
  ) u_dec (
    .sel_field_i  (bus_addr_i[TRIG_BIT-1:SEL_LSB]),
    .page_field_i (bus_addr_i[PAGE_LSB+PAGE_W-1:PAGE_LSB]),
    .reg_field_i  (bus_addr_i[REG_W-1:0]),
    .phy_sel_o    (dec_sel),
    .page_o       (dec_page),
    .reg_o        (dec_reg),
    .sel_ok_o     (sel_ok)
  );

  pb_req_ctrl #(
    .DW(DW), .NUM_PHY(NUM_PHY), .PAGE_W(PAGE_W), .REG_W(REG_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .sel_ok_i  (sel_ok),
    .sel_i     (dec_sel),
    .page_i    (dec_page),
    .reg_i     (dec_reg),
    .op_i      (op_q),
    .wdata_i   (bus_wdata_i),
    .ack_i     (phy_ack_i),
    .req_o     (phy_req_o),
    .sel_o     (phy_sel_o),
    .page_o    (phy_page_o),
    .reg_o     (phy_reg_o),
    .wr_en_o   (phy_wr_en_o),
    .wr_data_o (phy_wr_data_o),
    .busy_o    (busy_q),
    .err_o     (err_q),
    .rd_done_o (rd_done)
  );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int unsigned DW      = 16,
  parameter int unsigned NUM_PHY = 5,
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned REG_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [NUM_PHY-1:0] sel_i,
  input logic [PAGE_W-1:0]  page_i,
  input logic [REG_W-1:0]   reg_i,
  input logic               wr_en_i,
  input logic [DW-1:0]      wr_data_i,
  input logic               ack_i,
  input logic               busy_i,
  input logic               err_i,
  input logic [DW-1:0]      data_i
);
  a_r3_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !req_i);

  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ($countones(sel_i) == 1));

  a_r5_read_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_en_i) |-> (wr_data_i == '0));

  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && ack_i && !wr_en_i) |=> $stable(data_i));

  a_r7_busy_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !ack_i) |=> busy_i);

  a_r7_fields_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(sel_i) && $stable(page_i) &&
                                   $stable(reg_i) && $stable(wr_en_i) &&
                                   $stable(wr_data_i)));

  a_r8_no_req_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !req_i);

  a_r9_err_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> !req_i);
endmodule

bind phy_window_bridge pb_checker #(
  .DW(DW), .NUM_PHY(NUM_PHY), .PAGE_W(PAGE_W), .REG_W(REG_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (phy_req_o),
  .sel_i     (phy_sel_o),
  .page_i    (phy_page_o),
  .reg_i     (phy_reg_o),
  .wr_en_i   (phy_wr_en_o),
  .wr_data_i (phy_wr_data_o),
  .ack_i     (phy_ack_i),
  .busy_i    (busy_q),
  .err_i     (err_q),
  .data_i    (data_q)
);

// File: tb/phy_window_bridge_tb_top.sv
`timescale 1ns/1ps
module phy_window_bridge_tb_top;
  localparam logic [15:0] CTRL = 16'h8028;
  localparam logic [15:0] DATA = 16'h8029;

  typedef struct packed {
    logic [4:0]  sel;
    logic [2:0]  page;
    logic [4:0]  regn;
    logic        wr;
    logic [15:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        phy_req, phy_wr_en;
  logic [4:0]  phy_sel, phy_reg;
  logic [2:0]  phy_page;
  logic [15:0] phy_wr_data;
  logic        resp_ack = 1'b0, stray_ack = 1'b0;
  logic [15:0] resp_rdata = '0, stray_rdata = '0;
  logic        phy_ack;
  logic [15:0] phy_rdata;

  int   n_chk = 0, n_fail = 0;
  int   ack_delay = 2;
  logic [15:0] next_rdata = '0;
  logic        done = 1'b0;
  exp_t exp_q[$];
  exp_t e_got, e_exp;

  always #4 clk = ~clk;

  assign phy_ack   = resp_ack | stray_ack;
  assign phy_rdata = resp_ack ? resp_rdata : stray_rdata;

  phy_window_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .phy_req_o(phy_req), .phy_sel_o(phy_sel), .phy_page_o(phy_page),
    .phy_reg_o(phy_reg), .phy_wr_en_o(phy_wr_en), .phy_wr_data_o(phy_wr_data),
    .phy_ack_i(phy_ack), .phy_rdata_i(phy_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && phy_req) begin
      e_got = '{sel: phy_sel, page: phy_page, regn: phy_reg, wr: phy_wr_en, data: phy_wr_data};
      if (exp_q.size() == 0) begin
        chk("R8/R9/R10 unexpected request", {5'd0, e_got}, 32'h0);
      end else begin
        e_exp = exp_q.pop_front();
        chk("R3/R4/R5 request fields", {5'd0, e_got}, {5'd0, e_exp});
      end
    end
  end

  // PHY responder
  always begin
    @(negedge clk);
    if (rst_n && phy_req) begin
      repeat (ack_delay) @(negedge clk);
      resp_rdata = next_rdata;
      resp_ack   = 1'b1;
      @(negedge clk);
      resp_ack   = 1'b0;
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = '0;
  endtask

  function automatic logic [15:0] taddr(input logic [5:0] selbits, input logic [2:0] pg,
                                        input logic [4:0] rg);
    return {1'b1, selbits, 1'b0, pg, rg};
  endfunction

  task automatic push(input logic [4:0] s, input logic [2:0] p, input logic [4:0] r,
                      input logic w, input logic [15:0] d);
    exp_t e;
    e = '{sel: s, page: p, regn: r, wr: w, data: d};
    exp_q.push_back(e);
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 40; i++) begin
      bus_read(CTRL, v);
      if (!v[1]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_read(CTRL, v); chk("R1 ctrl after reset", 32'(v), 32'h0);
    bus_read(DATA, v); chk("R1 data after reset", 32'(v), 32'h0);
    chk("R1 no request in reset", 32'(phy_req), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 control register stores only bit 0
    bus_write(CTRL, 16'hFFFF);
    bus_read(CTRL, v); chk("R2 ctrl readback read op", 32'(v), 32'h1);
    bus_write(CTRL, 16'hFFFE);
    bus_read(CTRL, v); chk("R2 ctrl readback write op", 32'(v), 32'h0);

    // R3/R4 write access to PHY0, page 3, reg 7
    ack_delay = 3;
    push(5'b00001, 3'd3, 5'd7, 1'b1, 16'hBEEF);
    bus_write(taddr(6'b000001, 3'd3, 5'd7), 16'hBEEF);
    bus_read(CTRL, v); chk("R7 busy after trigger", 32'(v[1]), 32'h1);
    wait_idle();
    bus_read(CTRL, v); chk("R7 idle after ack", 32'(v[1]), 32'h0);
    bus_read(DATA, v); chk("R6 write completion leaves data", 32'(v), 32'h0);

    // R5/R6 read access to PHY4, page 7, reg 31; trigger data ignored
    bus_write(CTRL, 16'h0001);
    next_rdata = 16'hA5C3;
    push(5'b10000, 3'd7, 5'd31, 1'b0, 16'h0000);
    bus_write(taddr(6'b010000, 3'd7, 5'd31), 16'h1234);
    wait_idle();
    bus_read(DATA, v); chk("R5 R6 read data captured", 32'(v), 32'hA5C3);

    // R8 triggers while busy are ignored
    ack_delay = 6;
    next_rdata = 16'h0F1E;
    push(5'b00100, 3'd1, 5'd2, 1'b0, 16'h0000);
    bus_write(taddr(6'b000100, 3'd1, 5'd2), 16'h0000);
    bus_write(taddr(6'b001000, 3'd2, 5'd3), 16'h5555);
    bus_write(taddr(6'b000000, 3'd0, 5'd1), 16'h0000);
    bus_read(CTRL, v); chk("R8 error unchanged while busy", 32'(v[2:1]), 32'h1);
    wait_idle();
    bus_read(DATA, v); chk("R8 data from first read only", 32'(v), 32'h0F1E);

    // R9 invalid selects
    ack_delay = 1;
    bus_write(taddr(6'b000000, 3'd0, 5'd5), 16'h0);
    bus_read(CTRL, v); chk("R9 no select bit", 32'(v[2:1]), 32'h2);
    bus_write(CTRL, 16'h0000);
    bus_read(CTRL, v); chk("R9 error held across ctrl write", 32'(v), 32'h4);
    bus_write(taddr(6'b000011, 3'd0, 5'd5), 16'h0);
    bus_read(CTRL, v); chk("R9 two select bits", 32'(v[2:1]), 32'h2);
    bus_write(taddr(6'b100001, 3'd0, 5'd5), 16'h0);
    bus_read(CTRL, v); chk("R9 bit above last PHY", 32'(v[2:1]), 32'h2);
    push(5'b00010, 3'd5, 5'd9, 1'b1, 16'h00C4);
    bus_write(taddr(6'b000010, 3'd5, 5'd9), 16'h00C4);
    bus_read(CTRL, v); chk("R9 error cleared by valid trigger", 32'(v[2]), 32'h0);
    wait_idle();
    bus_read(DATA, v); chk("R6 data held after write op", 32'(v), 32'h0F1E);

    // R10 write with bit 15 clear
    bus_write(16'h0205, 16'hFFFF);
    bus_read(CTRL, v); chk("R10 low write no effect ctrl", 32'(v), 32'h0);
    bus_read(DATA, v); chk("R10 low write no effect data", 32'(v), 32'h0F1E);

    // R11 stray ack while idle
    @(negedge clk);
    stray_rdata = 16'hFFFF; stray_ack = 1'b1;
    @(negedge clk);
    stray_ack = 1'b0;
    bus_read(DATA, v); chk("R11 stray ack ignored data", 32'(v), 32'h0F1E);
    bus_read(CTRL, v); chk("R11 stray ack ignored ctrl", 32'(v), 32'h0);

    repeat (4) @(negedge clk);
    chk("R3 all expected requests seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule